// File: doc/BRIEF.md
# Register-Controlled FIR Sample Accelerator

The block computes one output of a direct-form FIR filter each time software asks for one. Software places a 16-bit signed sample in the sample register, raises and then lowers the start bit of the control register, polls the done register until it reads nonzero, and then reads the filtered value from the result register. The coefficient set is fixed when the block is built and passed in as a packed parameter vector. The filter order is set by a parameter.

One multiply-accumulate unit walks the taps one after another. Tap 0 is the newly latched sample, and taps 1 to ORDER come from a delay line of earlier samples. When the last product has been added, the accumulator is shifted arithmetically right by 15. The low 16 bits of that value become the result, and the delay line advances by one position.

Top module: `fir_accel`

## Requirements
- R1: After reset every readable register reads zero and the delay line holds zeros.
- R2: The register map uses word offsets on `bus_addr`. 0x0 holds the sample, read/write, with only bits 15:0 kept. 0x4 is the control register, read/write, with bit 0 as the start bit. 0x8 is done, read-only, in bit 0. 0xC is the result, read-only. Writes to 0x8 or 0xC change nothing. Any address with bits 1:0 not zero reads 0 and writes nothing.
- R3: A start is accepted only when a control write sets bit 0 while the stored bit 0 is 0 and the block is idle. Writing 1 again without first writing 0 does not start a new computation.
- R4: Done clears on the clock edge that accepts a start. It reads 1 again exactly ORDER+1 clock edges after that edge.
- R5: The result equals the low 16 bits of (sum over k = 0..ORDER of c[k]·x[n−k]) shifted arithmetically right by 15. The sum is held at least 2·16+3 bits wide, so it cannot overflow before the shift.
- R6: After each computation the delay line shifts by one position, and the sample just used becomes x[n−1] for the next computation.
- R7: A start written while a computation is running is ignored. The delay line shifts only once, and done is not cleared afterwards.
- R8: The sample is latched when the start is accepted. A sample write during the computation does not affect that result.
- R9: The result register reads as its 16-bit value sign-extended to 32 bits.
- R10: When the shifted sum does not fit in 16 bits, the result wraps, keeping only the low 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
A negative full-scale impulse followed by zeros makes each result the negated coefficient. This pattern separates every coefficient and every tap position, and exposes wrong ordering or a wrong delay-line shift. A mixed sequence of positive and negative samples checks sign handling in the products and the sign extension on readout. A constant near full scale forces the 16-bit wrap. Restarts and sample rewrites during a computation, compared with a model that shifts only once, distinguish a correctly ignored start from a double shift or a late sample latch.

// File: rtl/fir_accel_pkg.sv
package fir_accel_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    localparam int WORD_W    = 32;
    localparam int FRAC_BITS = 15;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic [WORD_W-1:0]          word_t;

    typedef enum logic [1:0] {
        REG_SAMPLE = 2'd0,
        REG_CTRL   = 2'd1,
        REG_DONE   = 2'd2,
        REG_RESULT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } seq_state_e;

    function automatic word_t widen(input sample_t v);
        return {{(WORD_W-SAMPLE_W){v[SAMPLE_W-1]}}, v};
    endfunction

    function automatic int acc_width(input int order);
        return SAMPLE_W + COEF_W + $clog2(order + 1) + 1;
    endfunction

endpackage

// File: rtl/fir_regs.sv
module fir_regs
    import fir_accel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  word_t      bus_wdata,
    input  logic       done,
    input  sample_t    result,
    output sample_t    sample_q,
    output logic       start_req,
    output word_t      bus_rdata
);
    logic     ctrl_q;
    logic     hit;
    reg_sel_e sel;
    logic     wr_sample, wr_ctrl;
    logic     unused_wbits;

    assign hit          = (bus_addr[1:0] == 2'b00);
    assign sel          = reg_sel_e'(bus_addr[3:2]);
    assign wr_sample    = bus_wr && hit && (sel == REG_SAMPLE);
    assign wr_ctrl      = bus_wr && hit && (sel == REG_CTRL);
    assign start_req    = wr_ctrl && bus_wdata[0] && !ctrl_q;
    assign unused_wbits = ^bus_wdata[WORD_W-1:SAMPLE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            ctrl_q   <= 1'b0;
        end else begin
            if (wr_sample) sample_q <= bus_wdata[SAMPLE_W-1:0];
            if (wr_ctrl)   ctrl_q   <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (sel)
                REG_SAMPLE: bus_rdata = widen(sample_q);
                REG_CTRL:   bus_rdata = {{(WORD_W-1){1'b0}}, ctrl_q};
                REG_DONE:   bus_rdata = {{(WORD_W-1){1'b0}}, done};
                REG_RESULT: bus_rdata = widen(result);
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fir_seq.sv
module fir_seq
    import fir_accel_pkg::*;
#(
    parameter int ORDER = 4,
    localparam int IDX_W = $clog2(ORDER + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    output logic             accept,
    output logic             busy,
    output logic             finish,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    seq_state_e state_q;
    logic       last;

    assign busy   = (state_q == ST_RUN);
    assign accept = start_req && (state_q == ST_IDLE);
    assign last   = (idx == IDX_W'(ORDER));
    assign finish = busy && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx     <= '0;
            done    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_RUN;
                    idx     <= '0;
                    done    <= 1'b0;
                end
                ST_RUN: if (last) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fir_delay.sv
module fir_delay
    import fir_accel_pkg::*;
#(
    parameter int ORDER = 4,
    localparam int IDX_W = $clog2(ORDER + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             finish,
    input  sample_t          sample_in,
    input  logic [IDX_W-1:0] idx,
    output sample_t          tap
);
    sample_t x_snap;
    sample_t line_q [ORDER];

    always_ff @(posedge clk) begin
        if (rst)         x_snap <= '0;
        else if (accept) x_snap <= sample_in;
    end

    for (genvar i = 0; i < ORDER; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)         line_q[i] <= '0;
            else if (finish) line_q[i] <= (i == 0) ? x_snap : line_q[(i == 0) ? 0 : i-1];
        end
    end

    always_comb begin
        tap = x_snap;
        for (int i = 0; i < ORDER; i++) begin
            if (idx == IDX_W'(i + 1)) tap = line_q[i];
        end
    end
endmodule

// File: rtl/fir_mac.sv
module fir_mac
    import fir_accel_pkg::*;
#(
    parameter int ORDER = 4,
    parameter logic [(ORDER+1)*COEF_W-1:0] COEFS = '0,
    localparam int IDX_W = $clog2(ORDER + 1),
    localparam int ACC_W = acc_width(ORDER),
    localparam int PROD_W = SAMPLE_W + COEF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             finish,
    input  sample_t          tap,
    input  logic [IDX_W-1:0] idx,
    output sample_t          result_q
);
    coef_t                     coef;
    logic signed [PROD_W-1:0]  prod;
    logic signed [ACC_W-1:0]   acc_q, acc_next;

    always_comb begin
        coef = '0;
        for (int k = 0; k <= ORDER; k++) begin
            if (idx == IDX_W'(k)) coef = COEFS[k*COEF_W +: COEF_W];
        end
    end

    assign prod     = tap * coef;
    assign acc_next = acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            result_q <= '0;
        end else begin
            if (clear)     acc_q <= '0;
            else if (step) acc_q <= acc_next;
            if (finish)    result_q <= acc_next[FRAC_BITS +: SAMPLE_W];
        end
    end
endmodule

// File: rtl/fir_accel.sv
module fir_accel
    import fir_accel_pkg::*;
#(
    parameter int ORDER = 4,
    parameter logic [(ORDER+1)*COEF_W-1:0] COEFS =
        {16'h7FFF, 16'h0800, 16'hF000, 16'h2000, 16'h4000}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int IDX_W = $clog2(ORDER + 1);

    sample_t          sample_q, tap, result_q;
    logic             start_req, accept, busy, finish, out_done;
    logic [IDX_W-1:0] tap_idx;

    fir_regs u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .done(out_done), .result(result_q),
        .sample_q(sample_q), .start_req(start_req), .bus_rdata(bus_rdata)
    );

    fir_seq #(.ORDER(ORDER)) u_seq (
        .clk(clk), .rst(rst), .start_req(start_req), .accept(accept),
        .busy(busy), .finish(finish), .idx(tap_idx), .done(out_done)
    );

    fir_delay #(.ORDER(ORDER)) u_delay (
        .clk(clk), .rst(rst), .accept(accept), .finish(finish),
        .sample_in(sample_q), .idx(tap_idx), .tap(tap)
    );

    fir_mac #(.ORDER(ORDER), .COEFS(COEFS)) u_mac (
        .clk(clk), .rst(rst), .clear(accept), .step(busy),
        .finish(finish), .tap(tap), .idx(tap_idx), .result_q(result_q)
    );
endmodule

// File: rtl/fir_accel_chk.sv
module fir_accel_chk #(
    parameter int ORDER = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        accept,
    input logic        busy,
    input logic        done,
    input logic [15:0] result
);
    localparam int CNT_W = $clog2(ORDER + 2) + 1;
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= '0;
        else              run_cnt <= run_cnt + 1'b1;
    end

    // R4
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done);

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R4
    run_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == CNT_W'(ORDER + 1)));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(done) |-> $stable(result));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !accept);
endmodule

bind fir_accel fir_accel_chk #(.ORDER(ORDER)) u_chk (
    .clk(clk), .rst(rst), .accept(accept), .busy(busy),
    .done(out_done), .result(result_q)
);

// File: tb/tb_fir_accel.sv
module tb_fir_accel;
    localparam int CLK_PERIOD = 10;
    localparam int ORDER = 4;
    localparam logic [79:0] COEF_VEC =
        {16'h7FFF, 16'h0800, 16'hF000, 16'h2000, 16'h4000};
    localparam longint C [0:ORDER] = '{16384, 8192, -4096, 2048, 32767};

    localparam logic [3:0] A_SAMPLE = 4'h0;
    localparam logic [3:0] A_CTRL   = 4'h4;
    localparam logic [3:0] A_DONE   = 4'h8;
    localparam logic [3:0] A_RESULT = 4'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;
    bit     finished = 0;
    longint hist [0:ORDER];

    fir_accel #(.ORDER(ORDER), .COEFS(COEF_VEC)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] model_next(input longint x);
        longint acc;
        longint sh;
        logic [15:0] r;
        acc = C[0] * x;
        for (int k = 1; k <= ORDER; k++) acc += C[k] * hist[k-1];
        sh = acc >>> 15;
        r = sh[15:0];
        return {{16{r[15]}}, r};
    endfunction

    task automatic model_shift(input longint x);
        for (int k = ORDER - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
    endtask

    task automatic wait_done(output int lat);
        logic [31:0] d;
        lat = -1;
        for (int i = 0; i < 50; i++) begin
            bus_read(A_DONE, d);
            if (d != 0) begin
                lat = i;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_sample(input string req, input logic signed [15:0] x);
        logic [31:0] d, exp;
        int lat;
        exp = model_next(longint'(x));
        bus_write(A_SAMPLE, {{16{x[15]}}, x});
        bus_write(A_CTRL, 32'd1);
        bus_write(A_CTRL, 32'd0);
        wait_done(lat);
        bus_read(A_RESULT, d);
        check(req, d, exp);
        model_shift(longint'(x));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_SAMPLE, d); check("R1 sample", d, 0);
        bus_read(A_CTRL, d);   check("R1 ctrl", d, 0);
        bus_read(A_DONE, d);   check("R1 done", d, 0);
        bus_read(A_RESULT, d); check("R1 result", d, 0);
    endtask

    task automatic t_impulse();
        // R5 R6: -full-scale impulse gives -c[k] in turn, then zero
        run_sample("R5 impulse tap0", -16'sd32768);
        for (int k = 1; k <= ORDER + 1; k++) run_sample("R6 impulse shift", 16'sd0);
    endtask

    task automatic t_mixed();
        // R9: negative results must read sign-extended
        run_sample("R9 mixed a", 16'sd1234);
        run_sample("R9 mixed b", -16'sd20000);
        run_sample("R5 mixed c", 16'sd7);
        run_sample("R5 mixed d", -16'sd1);
        run_sample("R9 mixed e", 16'sd30000);
    endtask

    task automatic t_wrap();
        for (int k = 0; k <= ORDER; k++) run_sample("R10 wrap", 16'sd32767);
    endtask

    task automatic t_latency();
        logic [31:0] d, exp;
        int c0;
        exp = model_next(longint'(100));
        bus_write(A_SAMPLE, 32'd100);
        bus_write(A_CTRL, 32'd1);
        c0 = cyc;
        bus_read(A_DONE, d);
        check("R4 done cleared", d, 0);
        bus_write(A_CTRL, 32'd0);
        for (int i = 0; i < 50; i++) begin
            bus_read(A_DONE, d);
            if (d != 0) break;
            @(negedge clk);
        end
        check("R4 latency", cyc - c0, ORDER + 1);
        bus_read(A_RESULT, d);
        check("R4 result", d, exp);
        model_shift(100);
        bus_write(A_CTRL, 32'd1);
        bus_write(A_CTRL, 32'd1);
        repeat (3) @(negedge clk);
        bus_read(A_DONE, d);
        check("R3 rewrite 1 ignored", d, 0);
        for (int i = 0; i < 20; i++) @(negedge clk);
        model_shift(100);
        bus_write(A_CTRL, 32'd0);
    endtask

    task automatic t_busy_start();
        logic [31:0] d, exp;
        exp = model_next(longint'(-500));
        bus_write(A_SAMPLE, 32'hFFFF_FE0C);
        bus_write(A_CTRL, 32'd1);
        bus_write(A_CTRL, 32'd0);
        bus_write(A_CTRL, 32'd1);
        bus_write(A_SAMPLE, 32'd9999);
        bus_write(A_CTRL, 32'd0);
        repeat (10) @(negedge clk);
        bus_read(A_DONE, d);
        check("R7 done stays set", d, 1);
        bus_read(A_RESULT, d);
        check("R8 latched sample", d, exp);
        model_shift(-500);
        run_sample("R7 single shift", 16'sd321);
    endtask

    task automatic t_readonly();
        logic [31:0] d, r0;
        bus_read(A_RESULT, r0);
        bus_write(A_RESULT, 32'h1234_5678);
        bus_write(A_DONE, 32'd0);
        bus_read(A_RESULT, d); check("R2 result read-only", d, r0);
        bus_read(A_DONE, d);   check("R2 done read-only", d, 1);
        bus_write(4'h1, 32'h0000_0001);
        bus_read(A_DONE, d);   check("R2 misaligned no start", d, 1);
        bus_read(4'h1, d);     check("R2 misaligned read", d, 0);
        bus_write(A_SAMPLE, 32'hABCD_8001);
        bus_read(A_SAMPLE, d); check("R2 sample width", d, 32'hFFFF_8001);
    endtask

    initial begin
        for (int k = 0; k <= ORDER; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_impulse();
        t_mixed();
        t_wrap();
        t_latency();
        t_busy_start();
        t_readonly();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule